// File: doc/BRIEF.md
# Stuck-At Fault Sweep Harness for an AND Gate

This block wraps an AND gate with `IN_W` inputs and runs a complete single stuck-at campaign on it. The nets are the gate inputs (net 0 is the most significant pattern bit) and the gate output (net `IN_W`). A fault register selects one net and a stuck value, and forces that net to the constant whatever drives it. A second, untouched copy of the gate acts as the fault-free reference.

After reset the sequencer visits every single stuck-at fault in turn. For each fault it drives every input pattern, one per clock, and compares the faulty output with the reference. For each fault it keeps the set of detecting patterns, a detected flag and the lowest detecting pattern. A one-cycle completion pulse marks the end of the campaign. The block then idles with no fault selected and holds its results until the next reset. A constant output gives the number of single plus multiple stuck-at combinations for the block's net count.

Top module: `saf_tester`

## Requirements
- R1: The selected net is held at the stuck value whatever its driver (stuck-at-0 gives 0, stuck-at-1 gives 1). `mismatch` is high in a cycle exactly when the faulty gate output differs from the fault-free output for the current pattern and fault.
- R2: The fault index runs 0 to 2*(IN_W+1)-1 in ascending order after reset. Fault f selects net `cur_net` = f/2 with stuck value `cur_stuck` = f mod 2. Nets 0..IN_W-1 are inputs, with net j driven by pattern bit IN_W-1-j, and net IN_W is the output.
- R3: Each fault gets all 2^IN_W patterns, in ascending order (00, 01, 10, 11 for two inputs), one per clock. A full campaign takes 2^IN_W * 2*(IN_W+1) clocks from reset release to the `done` cycle.
- R4: Bit p of fault f's field in `det_mask` (bit f*2^IN_W+p) is set exactly when pattern p caused a mismatch under fault f.
- R5: `det_flag[f]` is set when fault f produced any mismatch. It then stays set until reset. `first_pat` field f (bits f*IN_W upward) holds the lowest detecting pattern, or 0 when the fault was not detected.
- R6: `done` is high for exactly one cycle, the cycle after the last pattern of the last fault. From that cycle on the block applies the no-fault code (`cur_net` = IN_W+1, `cur_stuck` = 0, `cur_pat` = 0), `mismatch` stays low and the results hold.
- R7: A synchronous active-high reset, including one in mid-campaign, clears all flags, masks, first-pattern fields and `done`, and restarts at fault 0, pattern 0.
- R8: `combo_count` equals 3^(IN_W+1) - 1: 26 for two inputs, 80 for three.
- R9: For two inputs, the fault order is A0, A1, B0, B1, Y0, Y1. Every fault is detected. The masks are 8, 2, 8, 4, 8, 7 and the first patterns are 3, 1, 3, 2, 3, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done | output | 1 | One-cycle campaign completion pulse |
| det_flag | output | 2*(IN_W+1) | Per-fault detected flag |
| det_mask | output | 2*(IN_W+1)*2^IN_W | Per-fault set of detecting patterns |
| first_pat | output | 2*(IN_W+1)*IN_W | Per-fault lowest detecting pattern |
| cur_net | output | clog2(IN_W+2) | Net index of the applied fault (IN_W+1 = none) |
| cur_stuck | output | 1 | Stuck value of the applied fault |
| cur_pat | output | IN_W | Input pattern being applied |
| mismatch | output | 1 | Faulty and reference outputs differ |
| combo_count | output | CNT_W | Constant count of single plus multiple stuck-at combinations |

## Verification
The bench builds two instances: the default two-input gate, and a three-input gate with 8 faults and 8 patterns per fault. The three-input instance runs a 64-step campaign with a 3-bit net index, where the no-fault code is 4 and the combination count is 80. It therefore exercises the derived widths, the generate loops over a wider input set, and an input net (B) in the middle of the gate rather than at its edges. Both campaigns are compared cycle by cycle against a behavioural fault model in the bench, and the default instance is also checked against the literal result table and against a reset in mid-campaign.

// File: rtl/saf_pkg.sv
`timescale 1ns/1ps
package saf_pkg;

   typedef enum logic [1:0] {
      SEQ_RUN  = 2'd0,
      SEQ_DONE = 2'd1,
      SEQ_IDLE = 2'd2
   } seq_state_e;

   // Single plus multiple stuck-at combinations over k sites: 3^k - 1
   function automatic int unsigned combos_of(input int unsigned k);
      int unsigned r;
      r = 1;
      for (int unsigned i = 0; i < k; i++) r = r * 3;
      return r - 1;
   endfunction

endpackage

// File: rtl/saf_golden.sv
`timescale 1ns/1ps
module saf_golden #(
   parameter int IN_W = 2
) (
   input  logic [IN_W-1:0] pat,
   output logic            y
);
   assign y = &pat;
endmodule

// File: rtl/saf_inject.sv
`timescale 1ns/1ps
module saf_inject #(
   parameter int IN_W = 2,
   parameter int NI_W = 2
) (
   input  logic [IN_W-1:0] pat,
   input  logic [NI_W-1:0] net_idx,
   input  logic            stuck,
   output logic            y
);
   localparam logic [NI_W-1:0] OUT_IDX = NI_W'(IN_W);

   logic [IN_W-1:0] net_val;
   logic            core_y;

   // Net j is fed by pattern bit IN_W-1-j unless it is the selected fault site
   for (genvar j = 0; j < IN_W; j++) begin : g_in
      localparam logic [NI_W-1:0] JIDX = NI_W'(j);
      assign net_val[j] = (net_idx == JIDX) ? stuck : pat[IN_W-1-j];
   end

   assign core_y = &net_val;
   assign y      = (net_idx == OUT_IDX) ? stuck : core_y;
endmodule

// File: rtl/saf_seq.sv
`timescale 1ns/1ps
module saf_seq
   import saf_pkg::*;
#(
   parameter int IN_W = 2,
   parameter int NF   = 6,
   parameter int FI_W = 3,
   parameter int NI_W = 2
) (
   input  logic            clk,
   input  logic            rst,
   output logic [FI_W-1:0] fidx,
   output logic [IN_W-1:0] pidx,
   output logic            run,
   output logic            done,
   output logic [NI_W-1:0] net_idx,
   output logic            stuck
);
   localparam logic [FI_W-1:0] LAST_F  = FI_W'(NF - 1);
   localparam logic [IN_W-1:0] LAST_P  = '1;
   localparam logic [NI_W-1:0] NO_FLT  = NI_W'(IN_W + 1);

   seq_state_e state;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= SEQ_RUN;
         fidx  <= '0;
         pidx  <= '0;
      end else begin
         case (state)
            SEQ_RUN: begin
               if (pidx == LAST_P) begin
                  pidx <= '0;
                  if (fidx == LAST_F) begin
                     fidx  <= '0;
                     state <= SEQ_DONE;
                  end else begin
                     fidx <= fidx + 1'b1;
                  end
               end else begin
                  pidx <= pidx + 1'b1;
               end
            end
            SEQ_DONE: state <= SEQ_IDLE;
            default:  state <= SEQ_IDLE;
         endcase
      end
   end

   assign run     = (state == SEQ_RUN);
   assign done    = (state == SEQ_DONE);
   assign net_idx = run ? NI_W'(fidx >> 1) : NO_FLT;
   assign stuck   = run & fidx[0];
endmodule

// File: rtl/saf_log.sv
`timescale 1ns/1ps
module saf_log #(
   parameter int IN_W = 2,
   parameter int NF   = 6,
   parameter int NP   = 4,
   parameter int FI_W = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               rec_en,
   input  logic               mis,
   input  logic [FI_W-1:0]    fidx,
   input  logic [IN_W-1:0]    pidx,
   output logic [NF-1:0]      det_flag,
   output logic [NF*NP-1:0]   det_mask,
   output logic [NF*IN_W-1:0] first_pat
);
   for (genvar g = 0; g < NF; g++) begin : g_flt
      localparam logic [FI_W-1:0] GIDX = FI_W'(g);

      logic            hit;
      logic            flag_q;
      logic [NP-1:0]   mask_q;
      logic [IN_W-1:0] first_q;

      assign hit = rec_en & mis & (fidx == GIDX);

      always_ff @(posedge clk) begin
         if (rst) begin
            flag_q  <= 1'b0;
            mask_q  <= '0;
            first_q <= '0;
         end else if (hit) begin
            flag_q       <= 1'b1;
            mask_q[pidx] <= 1'b1;
            if (!flag_q) first_q <= pidx;
         end
      end

      assign det_flag[g]                = flag_q;
      assign det_mask[g*NP +: NP]       = mask_q;
      assign first_pat[g*IN_W +: IN_W]  = first_q;
   end
endmodule

// File: rtl/saf_tester.sv
`timescale 1ns/1ps
module saf_tester
   import saf_pkg::*;
#(
   parameter int IN_W  = 2,
   parameter int CNT_W = 16
) (
   input  logic                                clk,
   input  logic                                rst,
   output logic                                done,
   output logic [2*(IN_W+1)-1:0]               det_flag,
   output logic [2*(IN_W+1)*(1<<IN_W)-1:0]     det_mask,
   output logic [2*(IN_W+1)*IN_W-1:0]          first_pat,
   output logic [$clog2(IN_W+2)-1:0]           cur_net,
   output logic                                cur_stuck,
   output logic [IN_W-1:0]                     cur_pat,
   output logic                                mismatch,
   output logic [CNT_W-1:0]                    combo_count
);
   localparam int          NETS  = IN_W + 1;
   localparam int          NF    = 2 * NETS;
   localparam int          NP    = 1 << IN_W;
   localparam int          FI_W  = $clog2(NF);
   localparam int          NI_W  = $clog2(NETS + 1);
   localparam int unsigned COMBO = combos_of(NETS);

   if (IN_W < 1 || IN_W > 6) begin : g_bad_width
      $error("saf_tester: IN_W must lie in 1..6");
   end
   if (CNT_W < 1 || CNT_W > 31 || COMBO >= (32'd1 << CNT_W)) begin : g_bad_cnt
      $error("saf_tester: CNT_W too narrow for the combination count");
   end

   logic [FI_W-1:0] fidx;
   logic            run;
   logic            y_faulty;
   logic            y_golden;

   saf_seq #(.IN_W(IN_W), .NF(NF), .FI_W(FI_W), .NI_W(NI_W)) u_seq (
      .clk     (clk),
      .rst     (rst),
      .fidx    (fidx),
      .pidx    (cur_pat),
      .run     (run),
      .done    (done),
      .net_idx (cur_net),
      .stuck   (cur_stuck)
   );

   saf_inject #(.IN_W(IN_W), .NI_W(NI_W)) u_inj (
      .pat     (cur_pat),
      .net_idx (cur_net),
      .stuck   (cur_stuck),
      .y       (y_faulty)
   );

   saf_golden #(.IN_W(IN_W)) u_ref (
      .pat (cur_pat),
      .y   (y_golden)
   );

   assign mismatch = y_faulty ^ y_golden;

   saf_log #(.IN_W(IN_W), .NF(NF), .NP(NP), .FI_W(FI_W)) u_log (
      .clk       (clk),
      .rst       (rst),
      .rec_en    (run),
      .mis       (mismatch),
      .fidx      (fidx),
      .pidx      (cur_pat),
      .det_flag  (det_flag),
      .det_mask  (det_mask),
      .first_pat (first_pat)
   );

   assign combo_count = CNT_W'(COMBO);
endmodule

// File: rtl/saf_tester_chk.sv
`timescale 1ns/1ps
module saf_tester_chk #(
   parameter int IN_W = 2
) (
   input logic                            clk,
   input logic                            rst,
   input logic                            done,
   input logic [2*(IN_W+1)-1:0]           det_flag,
   input logic [2*(IN_W+1)*(1<<IN_W)-1:0] det_mask,
   input logic [2*(IN_W+1)*IN_W-1:0]      first_pat,
   input logic [$clog2(IN_W+2)-1:0]       cur_net,
   input logic                            cur_stuck,
   input logic [IN_W-1:0]                 cur_pat,
   input logic                            mismatch,
   input logic                            faulty_y
);
   localparam int NF   = 2 * (IN_W + 1);
   localparam int NP   = 1 << IN_W;
   localparam int NI_W = $clog2(IN_W + 2);
   localparam logic [NI_W-1:0] OUT_N = NI_W'(IN_W);
   localparam logic [NI_W-1:0] NONE  = NI_W'(IN_W + 1);

   logic          active;
   logic          last_f;
   logic [NF-1:0] prev_flag;
   logic          prev_vld;

   assign active = (cur_net != NONE);
   assign last_f = (cur_net == OUT_N) && cur_stuck;

   always_ff @(posedge clk) begin
      prev_flag <= det_flag;
      prev_vld  <= !rst;
   end

   AST_OUT_FORCED: assert property (@(posedge clk) disable iff (rst)
      (cur_net == OUT_N) |-> (faulty_y == cur_stuck)); // R1
   AST_IN_SA0_KILLS: assert property (@(posedge clk) disable iff (rst)
      (cur_net < OUT_N && !cur_stuck) |-> !faulty_y); // R1
   AST_PAT_STEP: assert property (@(posedge clk) disable iff (rst)
      (active && cur_pat != '1) |=> (cur_pat == $past(cur_pat) + 1'b1)); // R3
   AST_FAULT_STEP: assert property (@(posedge clk) disable iff (rst)
      (active && cur_pat == '1 && !last_f) |=>
         ({cur_net, cur_stuck} == $past({cur_net, cur_stuck}) + 1'b1)); // R2
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
      (last_f && cur_pat == '1) |=> done); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !active |-> !mismatch); // R6
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      prev_vld |-> ((det_flag & prev_flag) == prev_flag)); // R5
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (det_flag == '0 && det_mask == '0 && !done && cur_pat == '0)); // R7

   for (genvar g = 0; g < NF; g++) begin : g_f
      AST_FLAG_MASK: assert property (@(posedge clk) disable iff (rst)
         det_flag[g] == (|det_mask[g*NP +: NP])); // R5
      AST_FIRST_HIT: assert property (@(posedge clk) disable iff (rst)
         det_flag[g] |-> det_mask[g*NP + int'(first_pat[g*IN_W +: IN_W])]); // R4
   end
endmodule

bind saf_tester saf_tester_chk #(.IN_W(IN_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .done      (done),
   .det_flag  (det_flag),
   .det_mask  (det_mask),
   .first_pat (first_pat),
   .cur_net   (cur_net),
   .cur_stuck (cur_stuck),
   .cur_pat   (cur_pat),
   .mismatch  (mismatch),
   .faulty_y  (y_faulty)
);

// File: tb/test_saf_tester.sv
`timescale 1ns/1ps
module test_saf_tester;

   logic clk   = 1'b0;
   logic rst_a = 1'b1;
   logic rst_b = 1'b1;

   always #5 clk = ~clk;

   logic        a_done, a_stuck, a_mis;
   logic [5:0]  a_flag;
   logic [23:0] a_mask;
   logic [11:0] a_first;
   logic [1:0]  a_net, a_pat;
   logic [15:0] a_combo;

   logic        b_done, b_stuck, b_mis;
   logic [7:0]  b_flag;
   logic [63:0] b_mask;
   logic [23:0] b_first;
   logic [2:0]  b_net, b_pat;
   logic [15:0] b_combo;

   int n_vec = 0;
   int n_bad = 0;

   saf_tester i_saf_tester (
      .clk(clk), .rst(rst_a), .done(a_done), .det_flag(a_flag), .det_mask(a_mask),
      .first_pat(a_first), .cur_net(a_net), .cur_stuck(a_stuck), .cur_pat(a_pat),
      .mismatch(a_mis), .combo_count(a_combo)
   );

   saf_tester #(.IN_W(3)) i_saf_tester_w3 (
      .clk(clk), .rst(rst_b), .done(b_done), .det_flag(b_flag), .det_mask(b_mask),
      .first_pat(b_first), .cur_net(b_net), .cur_stuck(b_stuck), .cur_pat(b_pat),
      .mismatch(b_mis), .combo_count(b_combo)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Behavioural fault model
   function automatic int mdl_mis(input int w, input int f, input int p);
      int net, sv, good, bad;
      net  = f / 2;
      sv   = f % 2;
      good = (p == (1 << w) - 1) ? 1 : 0;
      if (net == w) bad = sv;
      else begin
         bad = 1;
         for (int j = 0; j < w; j++) begin
            int v;
            v = (j == net) ? sv : ((p >> (w - 1 - j)) & 1);
            bad = bad & v;
         end
      end
      return (good != bad) ? 1 : 0;
   endfunction

   function automatic int mdl_mask(input int w, input int f);
      int m = 0;
      for (int p = 0; p < (1 << w); p++) if (mdl_mis(w, f, p) != 0) m |= (1 << p);
      return m;
   endfunction

   function automatic int mdl_first(input int w, input int f);
      for (int p = 0; p < (1 << w); p++) if (mdl_mis(w, f, p) != 0) return p;
      return 0;
   endfunction

   function automatic int g_net(input int s);   return s ? int'(b_net)   : int'(a_net);   endfunction
   function automatic int g_stuck(input int s); return s ? int'(b_stuck) : int'(a_stuck); endfunction
   function automatic int g_pat(input int s);   return s ? int'(b_pat)   : int'(a_pat);   endfunction
   function automatic int g_mis(input int s);   return s ? int'(b_mis)   : int'(a_mis);   endfunction
   function automatic int g_done(input int s);  return s ? int'(b_done)  : int'(a_done);  endfunction
   function automatic int g_flag(input int s, input int f);
      return s ? int'(b_flag[f]) : int'(a_flag[f]);
   endfunction
   function automatic int g_mask(input int s, input int f);
      return s ? int'(b_mask[f*8 +: 8]) : int'(a_mask[f*4 +: 4]);
   endfunction
   function automatic int g_first(input int s, input int f);
      return s ? int'(b_first[f*3 +: 3]) : int'(a_first[f*2 +: 2]);
   endfunction

   task automatic t_reset_state();
      repeat (3) @(negedge clk);
      for (int s = 0; s < 2; s++) begin
         chk("R7 reset done", g_done(s), 0);
         chk("R7 reset net", g_net(s), 0);
         chk("R7 reset stuck", g_stuck(s), 0);
         chk("R7 reset pattern", g_pat(s), 0);
         for (int f = 0; f < (s ? 8 : 6); f++) begin
            chk("R7 reset flag", g_flag(s, f), 0);
            chk("R7 reset mask", g_mask(s, f), 0);
         end
      end
      chk("R8 combos two-input", int'(a_combo), 26);
      chk("R8 combos three-input", int'(b_combo), 80);
   endtask

   task automatic t_sweep(input int s);
      int w, nf, np;
      w  = s ? 3 : 2;
      nf = 2 * (w + 1);
      np = 1 << w;
      if (s != 0) rst_b = 1'b0; else rst_a = 1'b0;
      for (int f = 0; f < nf; f++) begin
         for (int p = 0; p < np; p++) begin
            chk("R2 fault net", g_net(s), f / 2);
            chk("R2 fault stuck", g_stuck(s), f % 2);
            chk("R3 pattern order", g_pat(s), p);
            chk("R1 mismatch", g_mis(s), mdl_mis(w, f, p));
            chk("R6 no early done", g_done(s), 0);
            @(negedge clk);
         end
      end
      chk("R6 done pulse", g_done(s), 1);
      chk("R6 no-fault code", g_net(s), w + 1);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R6 done single", g_done(s), 0);
         chk("R6 idle quiet", g_mis(s), 0);
         chk("R6 idle code", g_net(s), w + 1);
         chk("R6 idle stuck", g_stuck(s), 0);
      end
      for (int f = 0; f < nf; f++) begin
         chk("R4 mask", g_mask(s, f), mdl_mask(w, f));
         chk("R5 flag", g_flag(s, f), (mdl_mask(w, f) != 0) ? 1 : 0);
         chk("R5 first", g_first(s, f), mdl_first(w, f));
      end
   endtask

   task automatic t_table_two_input();
      int exp_m[6] = '{8, 2, 8, 4, 8, 7};
      int exp_f[6] = '{3, 1, 3, 2, 3, 0};
      for (int f = 0; f < 6; f++) begin
         chk("R9 mask table", g_mask(0, f), exp_m[f]);
         chk("R9 first table", g_first(0, f), exp_f[f]);
         chk("R9 all detected", g_flag(0, f), 1);
      end
   endtask

   task automatic t_midrun_reset();
      int n;
      rst_a = 1'b1;
      @(negedge clk);
      chk("R7 clear flags", int'(a_flag), 0);
      chk("R7 clear masks", int'(a_mask != 24'd0), 0);
      chk("R7 clear first", int'(a_first), 0);
      rst_a = 1'b0;
      repeat (9) @(negedge clk);
      chk("R2 mid net", g_net(0), 1);
      chk("R3 mid pattern", g_pat(0), 1);
      chk("R5 partial flags", int'(a_flag), 3);
      rst_a = 1'b1;
      @(negedge clk);
      chk("R7 mid clear flags", int'(a_flag), 0);
      chk("R7 mid restart net", g_net(0), 0);
      chk("R7 mid restart pattern", g_pat(0), 0);
      rst_a = 1'b0;
      n = 0;
      while (a_done !== 1'b1 && n < 100) begin
         @(negedge clk);
         n++;
      end
      chk("R3 campaign length", n, 24);
      @(negedge clk);
      chk("R6 pulse ends", g_done(0), 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      t_reset_state();
      t_sweep(0);
      t_table_two_input();
      t_sweep(1);
      t_midrun_reset();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule